// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes an incoming frame as a byte stream and places it in memory buffers. Each byte arrives with a valid flag and a last marker. The buffers are found through a ring of 8-byte descriptors. The engine adds a 4-byte CRC-32 check value after the payload. It fills each buffer up to a programmed size and then writes back that descriptor's length and status flags. It moves around the ring, returning to the ring base wherever a descriptor carries the wrap flag.

Software prepares the descriptors, raises the enable input and pulses the activate strobe. The engine reads the current descriptor and reports through `rx_active` whether that descriptor is free to fill. One pulse comes out per filled buffer and one per completed frame. When the ring runs out of free descriptors in the middle of a frame, the engine consumes the rest of that frame and discards it, then stops.

Descriptor layout: word 0 (offset 0) holds the byte count in bits 15:0 and the flags in bits 31:16. Word 1 (offset 4) holds the buffer byte address. The flag bits used are:

- bit 15: empty
- bit 13: wrap
- bit 11: last
- bit 5: too long
- bit 0: truncated

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the outputs are idle: `rx_active`, `in_ready`, `mem_req`, `ev_buffer` and `ev_frame` are all 0.
- R2: A one-cycle `rx_kick` while `rx_en` is 1 and `rx_active` is 0 reads word 0 of the current descriptor and sets `rx_active` to its empty flag (bit 31 of word 0). With `rx_en` at 0 the strobe has no effect.
- R3: While `rx_en` is 0, the descriptor pointer is loaded from `ring_base`. Dropping `rx_en` forces `rx_active` to 0 on the next cycle.
- R4: `in_ready` is 1 only while `rx_active` is 1, so no byte is accepted while reception is off.
- R5: Payload bytes go to consecutive byte addresses starting at the descriptor's buffer address. Each buffer takes at most `buf_size & 0x7F0` bytes, and the byte count placed in a buffer is written to bits 15:0 of its word 0.
- R6: The payload is followed by four check bytes, most significant byte first, and these bytes may be split across two buffers. The check value is the inverted result of the CRC-32 with reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF, taken over the stored payload. The stored frame length is the payload length plus 4.
- R7: Each filled descriptor is written back with the empty flag cleared and its other flags kept. The final descriptor of a frame also gets the last flag and the frame's error flags.
- R8: Payload bytes after byte 2028 are consumed and discarded, so at most 2032 bytes are stored. Such a frame gets both the truncated flag and the too-long flag.
- R9: A stored length greater than `frame_limit` sets the too-long flag alone. A length equal to the limit sets nothing.
- R10: `ev_buffer` pulses for one cycle for each filled non-final descriptor, and `ev_frame` pulses for one cycle for each final descriptor.
- R11: After a descriptor is filled, the pointer moves to `ring_base` if that descriptor has the wrap flag. Otherwise it moves forward by 8 bytes.
- R12: If the next descriptor is not empty in the middle of a frame, the rest of the frame is consumed and discarded. Nothing further is written, no `ev_frame` pulse is given, and `rx_active` ends at 0.
- R13: After a frame completes, `rx_active` takes the empty flag of the next descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable level |
| rx_kick | input | 1 | Activate strobe: re-check the current descriptor |
| ring_base | input | 32 | Byte address of the first descriptor |
| buf_size | input | 16 | Maximum bytes per buffer (masked with 0x7F0) |
| frame_limit | input | 16 | Maximum frame length before too-long is flagged |
| in_data | input | 8 | Incoming byte |
| in_valid | input | 1 | Incoming byte is valid |
| in_last | input | 1 | Incoming byte is the last payload byte |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_strb | output | 4 | Byte lane enables for writes |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rx_active | output | 1 | Reception is armed on an empty descriptor |
| ev_buffer | output | 1 | Non-final buffer filled (pulse) |
| ev_frame | output | 1 | Frame completed (pulse) |

## Verification
The assertions take several things for granted about the inputs:

- `buf_size` masks to a non-zero value, and it stays constant together with `frame_limit` and `ring_base` while a frame is in flight.
- The memory keeps returning the descriptor contents that software prepared.

The bench changes the configuration only after lowering `rx_en`, or while the engine sits idle between frames. It edits descriptors only when no memory access can be in progress, and every buffer size it drives masks to at least 16 bytes.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   localparam int FLG_EMPTY = 15;
   localparam int FLG_WRAP  = 13;
   localparam int FLG_LAST  = 11;
   localparam int FLG_LONG  = 5;
   localparam int FLG_TRUNC = 0;

   typedef enum logic [2:0] {
      S_OFF   = 3'd0,
      S_RD0   = 3'd1,
      S_RD1   = 3'd2,
      S_RUN   = 3'd3,
      S_WR    = 3'd4,
      S_CLOSE = 3'd5,
      S_DROP  = 3'd6
   } rxr_state_t;

endpackage

// File: rtl/rxr_crc32.sv
module rxr_crc32 #(
   parameter logic [31:0] POLY = 32'hEDB88320,
   parameter int          BITS_PER_STEP = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        upd,
   input  logic [7:0]  din,
   output logic [31:0] fcs
);
   logic [31:0] crc_q;
   logic [31:0] stage [BITS_PER_STEP+1];

   if (BITS_PER_STEP != 8) begin : g_bad_step
      $error("rxr_crc32: BITS_PER_STEP must be 8");
   end

   assign stage[0] = crc_q ^ {24'h0, din};

   for (genvar b = 0; b < BITS_PER_STEP; b++) begin : g_bit
      assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY) : (stage[b] >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= '1;
      else if (clr)    crc_q <= '1;
      else if (upd)    crc_q <= stage[BITS_PER_STEP];
   end

   assign fcs = ~crc_q;

   // R6: the register returns to all ones whenever a new frame starts
   a_r6_crc_init: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !upd) |=> (fcs == 32'h0));

endmodule

// File: rtl/rxr_len_track.sv
module rxr_len_track
   import rxr_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int STORE_MAX = 2032
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             store,
   input  logic             cut,
   input  logic [LEN_W-1:0] limit,
   output logic             at_cap,
   output logic [15:0]      err_flags
);
   localparam int          CRC_BYTES = 4;
   localparam int          PAY_CAP   = STORE_MAX - CRC_BYTES;
   localparam logic [LEN_W:0] CRC_ADD = (LEN_W+1)'(CRC_BYTES);

   logic [LEN_W-1:0] pay_cnt;
   logic             trunc_q;
   logic [LEN_W:0]   stored_len;

   if (STORE_MAX <= CRC_BYTES) begin : g_bad_store
      $error("rxr_len_track: STORE_MAX must exceed the check bytes");
   end
   if (STORE_MAX >= (1 << LEN_W)) begin : g_bad_width
      $error("rxr_len_track: LEN_W too narrow for STORE_MAX");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pay_cnt <= '0;
         trunc_q <= 1'b0;
      end else if (clr) begin
         pay_cnt <= '0;
         trunc_q <= 1'b0;
      end else begin
         if (store) pay_cnt <= pay_cnt + LEN_W'(1);
         if (cut)   trunc_q <= 1'b1;
      end
   end

   assign at_cap     = (pay_cnt == LEN_W'(PAY_CAP));
   assign stored_len = {1'b0, pay_cnt} + CRC_ADD;

   always_comb begin
      err_flags = 16'h0;
      if (trunc_q) begin
         err_flags[FLG_TRUNC] = 1'b1;
         err_flags[FLG_LONG]  = 1'b1;
      end
      if (stored_len > {1'b0, limit}) err_flags[FLG_LONG] = 1'b1;
   end

   // R8: the stored payload never grows past the cap
   a_r8_cap: assert property (@(posedge clk) disable iff (!rst_n)
      pay_cnt <= LEN_W'(PAY_CAP));

   // R8: a discard only ever happens once the cap has been reached
   a_r8_cut_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cut |-> at_cap && !store);

endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
   import rxr_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          LEN_W     = 16,
   parameter int          STORE_MAX = 2032,
   parameter logic [15:0] BUF_MASK  = 16'h07F0,
   parameter logic [31:0] CRC_POLY  = 32'hEDB88320
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rx_kick,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [15:0]       buf_size,
   input  logic [LEN_W-1:0]  frame_limit,
   input  logic [7:0]        in_data,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              in_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_strb,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              rx_active,
   output logic              ev_buffer,
   output logic              ev_frame
);
   localparam int              DESC_BYTES = 8;
   localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(DESC_BYTES);
   localparam logic [ADDR_W-1:0] WORD1_OFS = ADDR_W'(DESC_BYTES / 2);
   localparam logic [15:0]     EMPTY_BIT  = 16'h1 << FLG_EMPTY;
   localparam logic [15:0]     LAST_BIT   = 16'h1 << FLG_LAST;

   if (ADDR_W > 32 || ADDR_W < 8) begin : g_bad_addr
      $error("rx_desc_ring: ADDR_W must be between 8 and 32");
   end
   if (LEN_W != 16) begin : g_bad_len
      $error("rx_desc_ring: descriptor length field is 16 bits");
   end
   if (BUF_MASK[3:0] != 4'h0) begin : g_bad_mask
      $error("rx_desc_ring: BUF_MASK must keep whole 16-byte units");
   end

   rxr_state_t        st;
   logic              act_q;
   logic [ADDR_W-1:0] desc_ptr;
   logic [ADDR_W-1:0] buf_ptr;
   logic [15:0]       old_flags;
   logic [15:0]       fill;
   logic [7:0]        hold_byte;
   logic              hold_v;
   logic              in_crc;
   logic [1:0]        crc_idx;
   logic              mid;
   logic              final_q;
   logic              ev_b_q;
   logic              ev_f_q;

   logic [15:0]       buf_lim;
   logic [15:0]       fill_nx;
   logic [ADDR_W-1:0] byte_addr;
   logic [31:0]       fcs;
   logic [7:0]        fcs_byte;
   logic [7:0]        wbyte;
   logic [15:0]       err_flags;
   logic [15:0]       close_flags;
   logic              at_cap;
   logic              take;
   logic              store;
   logic              cut;
   logic              frame_clr;
   logic              rd_empty;
   logic              wr_done;

   assign buf_lim   = buf_size & BUF_MASK;
   assign fill_nx   = fill + 16'd1;
   assign byte_addr = buf_ptr + ADDR_W'(fill);
   assign rd_empty  = mem_rdata[16 + FLG_EMPTY];
   assign take      = (st == S_RUN) && in_valid;
   assign store     = take && !at_cap;
   assign cut       = take && at_cap;
   assign frame_clr = (st == S_RD1) && mem_ack && !mid;
   assign wr_done   = !hold_v && (crc_idx == 2'd3);

   always_comb begin
      unique case (crc_idx)
         2'd0: fcs_byte = fcs[31:24];
         2'd1: fcs_byte = fcs[23:16];
         2'd2: fcs_byte = fcs[15:8];
         default: fcs_byte = fcs[7:0];
      endcase
   end

   assign wbyte       = hold_v ? hold_byte : fcs_byte;
   assign close_flags = (old_flags & ~EMPTY_BIT) | (final_q ? (LAST_BIT | err_flags) : 16'h0);

   rxr_crc32 #(
      .POLY          (CRC_POLY),
      .BITS_PER_STEP (8)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_clr),
      .upd   (store),
      .din   (in_data),
      .fcs   (fcs)
   );

   rxr_len_track #(
      .LEN_W     (LEN_W),
      .STORE_MAX (STORE_MAX)
   ) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (frame_clr),
      .store     (store),
      .cut       (cut),
      .limit     (frame_limit),
      .at_cap    (at_cap),
      .err_flags (err_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_OFF;
         act_q     <= 1'b0;
         desc_ptr  <= '0;
         buf_ptr   <= '0;
         old_flags <= '0;
         fill      <= '0;
         hold_byte <= '0;
         hold_v    <= 1'b0;
         in_crc    <= 1'b0;
         crc_idx   <= '0;
         mid       <= 1'b0;
         final_q   <= 1'b0;
         ev_b_q    <= 1'b0;
         ev_f_q    <= 1'b0;
      end else begin
         ev_b_q <= 1'b0;
         ev_f_q <= 1'b0;
         if (!rx_en) begin
            st       <= S_OFF;
            act_q    <= 1'b0;
            desc_ptr <= ring_base;
         end else begin
            unique case (st)
               S_OFF: begin
                  if (rx_kick && !act_q) begin
                     mid <= 1'b0;
                     st  <= S_RD0;
                  end
               end
               S_RD0: begin
                  if (mem_ack) begin
                     old_flags <= mem_rdata[31:16];
                     if (mid) begin
                        if (rd_empty) st <= S_RD1;
                        else if (in_crc) begin
                           st    <= S_OFF;
                           act_q <= 1'b0;
                        end else st <= S_DROP;
                     end else begin
                        act_q <= rd_empty;
                        st    <= rd_empty ? S_RD1 : S_OFF;
                     end
                  end
               end
               S_RD1: begin
                  if (mem_ack) begin
                     buf_ptr <= mem_rdata[ADDR_W-1:0];
                     fill    <= '0;
                     if (mid) begin
                        st <= in_crc ? S_WR : S_RUN;
                     end else begin
                        in_crc  <= 1'b0;
                        crc_idx <= '0;
                        hold_v  <= 1'b0;
                        st      <= S_RUN;
                     end
                  end
               end
               S_RUN: begin
                  if (in_valid) begin
                     if (in_last) in_crc <= 1'b1;
                     if (!at_cap) begin
                        hold_byte <= in_data;
                        hold_v    <= 1'b1;
                        st        <= S_WR;
                     end else if (in_last) begin
                        st <= S_WR;
                     end
                  end
               end
               S_WR: begin
                  if (mem_ack) begin
                     fill <= fill_nx;
                     if (hold_v) hold_v  <= 1'b0;
                     else        crc_idx <= crc_idx + 2'd1;
                     if (wr_done) begin
                        final_q <= 1'b1;
                        st      <= S_CLOSE;
                     end else if (fill_nx == buf_lim) begin
                        final_q <= 1'b0;
                        st      <= S_CLOSE;
                     end else begin
                        st <= in_crc ? S_WR : S_RUN;
                     end
                  end
               end
               S_CLOSE: begin
                  if (mem_ack) begin
                     if (final_q) ev_f_q <= 1'b1;
                     else         ev_b_q <= 1'b1;
                     desc_ptr <= old_flags[FLG_WRAP] ? ring_base : desc_ptr + DESC_STEP;
                     mid      <= !final_q;
                     st       <= S_RD0;
                  end
               end
               S_DROP: begin
                  if (in_valid && in_last) begin
                     st    <= S_OFF;
                     act_q <= 1'b0;
                  end
               end
               default: st <= S_OFF;
            endcase
         end
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = desc_ptr;
      mem_wdata = 32'h0;
      mem_strb  = 4'h0;
      unique case (st)
         S_RD0: mem_req = 1'b1;
         S_RD1: begin
            mem_req  = 1'b1;
            mem_addr = desc_ptr + WORD1_OFS;
         end
         S_WR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {byte_addr[ADDR_W-1:2], 2'b00};
            mem_strb  = 4'b0001 << byte_addr[1:0];
            mem_wdata = {4{wbyte}};
         end
         S_CLOSE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_strb  = 4'hF;
            mem_wdata = {close_flags, fill};
         end
         default: ;
      endcase
   end

   assign in_ready  = (st == S_RUN) || (st == S_DROP);
   assign rx_active = act_q;
   assign ev_buffer = ev_b_q;
   assign ev_frame  = ev_f_q;

   // R4: bytes are taken only while reception is armed
   a_r4_ready_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> rx_active);

   // R3: clearing the enable turns reception off on the next cycle
   a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_active);

   // R2: reception can only become armed right after a descriptor read
   a_r2_arm_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_active) |-> $past(mem_req && !mem_we && mem_ack));

   // R10: the two event pulses never coincide and last one cycle
   a_r10_events_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_buffer && ev_frame));
   a_r10_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ev_frame |=> !ev_frame);

   // R5: a pending memory request holds its address until acknowledged
   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && rx_en) |=> (!rx_en || (mem_req && $stable(mem_addr))));

   // R5: a byte write targets one lane inside the current buffer
   a_r5_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WR) |-> ($countones(mem_strb) == 1 && fill < buf_lim));

   // R12: after a drop starts nothing more is written to memory
   a_r12_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DROP) |-> !mem_req);

endmodule

// File: tb/test_rx_desc_ring.sv
`timescale 1ns/1ps
module test_rx_desc_ring;
   localparam int MEM_WORDS = 2304;
   localparam logic [31:0] RING = 32'h100;
   localparam int NV = 9;
   localparam int V_LEN [NV] = '{60, 100, 30, 28, 200, 2100, 20, 1, 1};
   localparam int V_BSZ [NV] = '{16'h7F0, 32, 16, 16, 16'h7F0, 16'h7F0, 16'h1F, 16'h7F0, 16'h7F0};
   localparam int V_LIM [NV] = '{1518, 1518, 1518, 1518, 100, 1518, 1518, 5, 4};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic        rx_kick = 1'b0;
   logic [31:0] ring_base = RING;
   logic [15:0] buf_size = 16'h7F0;
   logic [15:0] frame_limit = 16'd1518;
   logic [7:0]  in_data = 8'h0;
   logic        in_valid = 1'b0;
   logic        in_last = 1'b0;
   logic        in_ready;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_strb;
   logic        rx_active, ev_buffer, ev_frame;

   logic [31:0] mem [MEM_WORDS];
   logic        tb_we = 1'b0;
   logic [31:0] tb_addr = 32'h0;
   logic [31:0] tb_data = 32'h0;
   int          cnt_buf = 0;
   int          cnt_frm = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          timed_out = 1'b0;

   always #2 clk = ~clk;

   rx_desc_ring i_rx_desc_ring (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_kick(rx_kick),
      .ring_base(ring_base), .buf_size(buf_size), .frame_limit(frame_limit),
      .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_strb(mem_strb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rx_active(rx_active), .ev_buffer(ev_buffer), .ev_frame(ev_frame)
   );

   assign mem_ack   = mem_req;
   assign mem_rdata = ((mem_addr >> 2) < MEM_WORDS) ? mem[mem_addr >> 2] : 32'h0;

   always @(posedge clk) begin
      if (mem_req && mem_we && ((mem_addr >> 2) < MEM_WORDS)) begin
         for (int b = 0; b < 4; b++)
            if (mem_strb[b]) mem[mem_addr >> 2][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
      if (tb_we) mem[tb_addr >> 2] <= tb_data;
      if (ev_buffer) cnt_buf <= cnt_buf + 1;
      if (ev_frame)  cnt_frm <= cnt_frm + 1;
   end

   function automatic logic [7:0] pat(int seed, int i);
      return 8'((i * 13 + seed * 29 + 5) & 255);
   endfunction

   function automatic logic [31:0] ref_fcs(int n, int seed);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ {24'h0, pat(seed, i)};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return ~c;
   endfunction

   function automatic logic [7:0] rd_byte(logic [31:0] a);
      logic [31:0] w = mem[a >> 2];
      return w[8*a[1:0] +: 8];
   endfunction

   function automatic logic [31:0] buf_addr(int i);
      return 32'h400 + 32'(i) * 32'h800;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tb_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = a; tb_data = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic set_desc(input int i, input logic [15:0] flags, input logic [15:0] len);
      tb_write(RING + 32'(8 * i), {flags, len});
      tb_write(RING + 32'(8 * i) + 32'd4, buf_addr(i));
   endtask

   task automatic arm_all();
      for (int i = 0; i < 4; i++) set_desc(i, (i == 3) ? 16'hA000 : 16'h8000, 16'h0);
   endtask

   task automatic restart();
      @(negedge clk); rx_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic kick();
      @(negedge clk); rx_en = 1'b1; rx_kick = 1'b1;
      @(negedge clk); rx_kick = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic send(input int n, input int seed);
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         bit rdy = 1'b0;
         in_valid = 1'b1; in_data = pat(seed, i); in_last = (i == n - 1);
         while (!rdy) begin
            rdy = in_ready;
            @(posedge clk);
            @(negedge clk);
         end
      end
      in_valid = 1'b0; in_last = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   task automatic run_vec(input int v);
      int n = V_LEN[v], lim = V_LIM[v];
      int bsz = V_BSZ[v] & 16'h7F0;
      int p = (n > 2028) ? 2028 : n;
      int t = p + 4;
      int k = (t + bsz - 1) / bsz;
      int b0 = cnt_buf, f0 = cnt_frm, bad = 0;
      logic [15:0] err = 16'h0;
      logic [31:0] fcs = ref_fcs(p, v);
      restart();
      arm_all();
      buf_size = 16'(V_BSZ[v]); frame_limit = 16'(lim);
      kick();
      chk(rx_active == 1'b1, $sformatf("R2 vec%0d arm", v), 32'(rx_active), 32'h1);
      send(n, v);
      if (n > 2028) err = err | 16'h0021;
      if (t > lim)  err = err | 16'h0020;
      for (int d = 0; d < k; d++) begin
         logic [15:0] fl = (d == 3) ? 16'h2000 : 16'h0000;
         logic [15:0] ln = (d < k - 1) ? 16'(bsz) : 16'(t - (k - 1) * bsz);
         if (d == k - 1) fl = fl | 16'h0800 | err;
         chk(mem[(RING >> 2) + 2 * d] === {fl, ln},
             $sformatf("R7 R9 R8 vec%0d desc%0d word0", v, d), mem[(RING >> 2) + 2 * d], {fl, ln});
      end
      for (int j = 0; j < t; j++) begin
         logic [7:0] e = (j < p) ? pat(v, j) : fcs[8 * (3 - (j - p)) +: 8];
         if (rd_byte(buf_addr(j / bsz) + 32'(j % bsz)) !== e) bad++;
      end
      chk(bad == 0, $sformatf("R5 R6 vec%0d data bytes wrong", v), 32'(bad), 32'h0);
      chk(cnt_buf - b0 == k - 1 && cnt_frm - f0 == 1, $sformatf("R10 vec%0d events", v),
          32'((cnt_buf - b0) * 16 + (cnt_frm - f0)), 32'((k - 1) * 16 + 1));
      chk(rx_active == (k < 4), $sformatf("R13 R11 vec%0d rx_active after frame", v),
          32'(rx_active), 32'(k < 4));
   endtask

   task automatic directed();
      int b0, f0;
      logic [31:0] w;
      // R1: idle after reset
      chk({rx_active, in_ready, mem_req, ev_buffer, ev_frame} == 5'b0, "R1 reset outputs",
          32'({rx_active, in_ready, mem_req, ev_buffer, ev_frame}), 32'h0);
      // R2: strobe ignored while disabled
      arm_all();
      @(negedge clk); rx_kick = 1'b1; @(negedge clk); rx_kick = 1'b0;
      repeat (5) @(negedge clk);
      chk(rx_active == 1'b0 && in_ready == 1'b0, "R2 kick ignored when disabled",
          32'({rx_active, in_ready}), 32'h0);
      // R2 R4: current descriptor not empty keeps reception off
      set_desc(0, 16'h0000, 16'h0);
      kick();
      chk(rx_active == 1'b0 && in_ready == 1'b0, "R2 R4 busy descriptor", 32'({rx_active, in_ready}), 32'h0);
      // R12: stall mid-frame
      restart();
      set_desc(0, 16'h8000, 16'h0);
      set_desc(1, 16'h0000, 16'h1234);
      tb_write(buf_addr(1), 32'hDEADBEEF);
      buf_size = 16'd16; frame_limit = 16'd1518;
      b0 = cnt_buf; f0 = cnt_frm;
      kick();
      send(40, 50);
      chk(mem[RING >> 2] === 32'h0000_0010, "R12 R7 first descriptor", mem[RING >> 2], 32'h0000_0010);
      chk(mem[(RING >> 2) + 2] === 32'h0000_1234, "R12 busy descriptor untouched", mem[(RING >> 2) + 2], 32'h0000_1234);
      chk(mem[buf_addr(1) >> 2] === 32'hDEADBEEF, "R12 no write after stall", mem[buf_addr(1) >> 2], 32'hDEADBEEF);
      chk(cnt_buf - b0 == 1 && cnt_frm == f0, "R12 R10 events on stall",
          32'((cnt_buf - b0) * 16 + (cnt_frm - f0)), 32'h10);
      chk(rx_active == 1'b0 && in_ready == 1'b0, "R12 R4 off after stall", 32'({rx_active, in_ready}), 32'h0);
      // R11: wrap back to base across two frames
      restart();
      arm_all();
      buf_size = 16'd16;
      kick();
      send(44, 60);
      chk(rx_active == 1'b1, "R13 next descriptor empty", 32'(rx_active), 32'h1);
      set_desc(0, 16'h8000, 16'h0);
      b0 = cnt_buf; f0 = cnt_frm;
      send(20, 61);
      chk(mem[(RING >> 2) + 6] === 32'h2000_0010, "R11 R7 wrap descriptor keeps wrap flag",
          mem[(RING >> 2) + 6], 32'h2000_0010);
      chk(mem[RING >> 2] === 32'h0800_0008, "R11 continues at ring base", mem[RING >> 2], 32'h0800_0008);
      w = {24'h0, pat(61, 16)};
      chk({24'h0, rd_byte(buf_addr(0))} === w, "R11 R5 wrapped buffer data", {24'h0, rd_byte(buf_addr(0))}, w);
      chk(cnt_buf - b0 == 1 && cnt_frm - f0 == 1, "R10 wrap events",
          32'((cnt_buf - b0) * 16 + (cnt_frm - f0)), 32'h11);
      chk(rx_active == 1'b0, "R13 next descriptor already filled", 32'(rx_active), 32'h0);
      // R3: pointer reload from base and forced off
      restart();
      set_desc(0, 16'h8000, 16'h0);
      kick();
      chk(rx_active == 1'b1, "R3 pointer reloaded to base", 32'(rx_active), 32'h1);
      @(negedge clk); rx_en = 1'b0;
      @(negedge clk);
      chk(rx_active == 1'b0, "R3 disable forces off", 32'(rx_active), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      fork
         begin
            directed();
            for (int v = 0; v < NV; v++) run_vec(v);
         end
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R1..all actual=hung expected=done");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule